// File: doc/BRIEF.md
# Selectable Period Watchdog Supervisor

This block supervises a host processor and drives the system reset line. A slow enable pulse (`tick_ms`, one clock wide, nominally once per millisecond) paces every duration, so long timeouts cost only a counter. A two-bit period code chooses one of three timeouts or switches the watchdog off. The host shows that it is alive by producing traffic on a serial bus. A start-condition detector elsewhere on the chip turns each bus start into a one-cycle `bus_start` pulse, and each such pulse clears the running count.

When the count expires, reset is asserted for a fixed number of ticks. Counting then begins again from zero. After its own reset is released, the block also holds reset for a power-on interval. While a low-supply flag from an analog comparator is high, reset is forced, and the power-on interval restarts once the flag clears. Every tick count and the reset polarity are parameters.

Top module: `wdg_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is in its asserted state.
- R2: In the running state, with no restart, reset asserts on the clock edge that consumes the N-th tick since the last restart. N is `TICKS_LONG` (1400) for code 2'b00, `TICKS_MID` (600) for 2'b01 and `TICKS_SHORT` (200) for 2'b10.
- R3: Code 2'b11 disables the watchdog, so no timeout ever asserts reset. The block leaves reset with 2'b11 as its stored code.
- R4: A `bus_start` pulse in the running state clears the count to zero. Pulses spaced closer than the period keep reset deasserted.
- R5: A timeout holds reset for exactly `HOLD_TICKS` (200) ticks. The count then resumes from zero with the current code.
- R6: After `rst_n` rises, reset stays asserted for exactly `POR_TICKS` (200) ticks.
- R7: A change of `period_code` in the running state restarts the count from zero.
- R8: `supply_low` asserts reset at the next clock edge and holds it asserted. After the flag clears, reset stays asserted for `POR_TICKS` more ticks. A new low-supply event during that interval restarts it.
- R9: `bus_start` pulses and code changes while reset is held do not change the hold length.
- R10: With `RST_ACTIVE_HIGH` = 1, the asserted level of `sys_rst` is 1. With 0, it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_ms | input | 1 | One-cycle time-base enable that paces all durations |
| period_code | input | 2 | Timeout select: 00 long, 01 mid, 10 short, 11 off |
| bus_start | input | 1 | One-cycle restart pulse from the bus start detector |
| supply_low | input | 1 | High while the supply is below its trip point |
| sys_rst | output | 1 | System reset, polarity set by RST_ACTIVE_HIGH |

## Verification
The assertions assume three things about the inputs. `tick_ms` and `bus_start` are single-cycle pulses that are synchronous to `clk`. `period_code` and `supply_low` are already synchronized levels. Durations are judged by counting tick edges, not clock cycles. The bench keeps to these assumptions by driving every input one time unit after a rising edge, and by pulsing the tick for one cycle in every four. It lets codes and the supply flag change only between edges, so each restart, code change and supply event lands on a known edge that the tick-counting monitor sees too.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic {
        MODE_HOLD = 1'b0,
        MODE_RUN  = 1'b1
    } wdg_mode_e;

    localparam logic [1:0] CODE_LONG  = 2'b00;
    localparam logic [1:0] CODE_MID   = 2'b01;
    localparam logic [1:0] CODE_SHORT = 2'b10;
    localparam logic [1:0] CODE_OFF   = 2'b11;

endpackage

// File: rtl/wdg_period_decode.sv
module wdg_period_decode #(
    parameter int TICKS_LONG  = 1400,
    parameter int TICKS_MID   = 600,
    parameter int TICKS_SHORT = 200,
    parameter int CW          = 11
) (
    input  logic [1:0]    code,
    output logic [CW-1:0] limit_m1,
    output logic          enabled
);
    import wdg_pkg::*;

    always_comb begin
        enabled  = 1'b1;
        limit_m1 = CW'(TICKS_LONG - 1);
        case (code)
            CODE_LONG:  limit_m1 = CW'(TICKS_LONG - 1);
            CODE_MID:   limit_m1 = CW'(TICKS_MID - 1);
            CODE_SHORT: limit_m1 = CW'(TICKS_SHORT - 1);
            default:    enabled  = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdg_reset_drive.sv
module wdg_reset_drive #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic hold,
    output logic rst_out
);
    generate
        if (ACTIVE_HIGH) begin : g_high
            assign rst_out = hold;
        end else begin : g_low
            assign rst_out = ~hold;
        end
    endgenerate

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor #(
    parameter int TICKS_LONG      = 1400,
    parameter int TICKS_MID       = 600,
    parameter int TICKS_SHORT     = 200,
    parameter int HOLD_TICKS      = 200,
    parameter int POR_TICKS       = 200,
    parameter bit RST_ACTIVE_HIGH = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic [1:0] period_code,
    input  logic       bus_start,
    input  logic       supply_low,
    output logic       sys_rst
);
    import wdg_pkg::*;

    localparam int RUN_MAX  = (TICKS_LONG > TICKS_MID)
                            ? ((TICKS_LONG > TICKS_SHORT) ? TICKS_LONG : TICKS_SHORT)
                            : ((TICKS_MID > TICKS_SHORT) ? TICKS_MID : TICKS_SHORT);
    localparam int HOLD_MAX = (POR_TICKS > HOLD_TICKS) ? POR_TICKS : HOLD_TICKS;
    localparam int ALL_MAX  = (RUN_MAX > HOLD_MAX) ? RUN_MAX : HOLD_MAX;
    localparam int CW       = $clog2(ALL_MAX + 1);

    typedef struct packed {
        wdg_mode_e     mode;
        logic          por;
        logic [1:0]    code;
        logic [CW-1:0] run_cnt;
        logic [CW-1:0] hold_cnt;
    } wdg_state_t;

    wdg_state_t    st_d, st_q;
    logic [CW-1:0] limit_m1;
    logic          wd_enabled;
    logic [CW-1:0] hold_last;
    logic          restart;
    logic [CW-1:0] run_cnt_obs;
    logic [CW-1:0] hold_cnt_obs;

    wdg_period_decode #(
        .TICKS_LONG (TICKS_LONG),
        .TICKS_MID  (TICKS_MID),
        .TICKS_SHORT(TICKS_SHORT),
        .CW         (CW)
    ) u_decode (
        .code    (period_code),
        .limit_m1(limit_m1),
        .enabled (wd_enabled)
    );

    assign hold_last = st_q.por ? CW'(POR_TICKS - 1) : CW'(HOLD_TICKS - 1);
    assign restart   = !wd_enabled || bus_start || (period_code != st_q.code);

    always_comb begin
        st_d      = st_q;
        st_d.code = period_code;
        if (supply_low) begin
            st_d.mode     = MODE_HOLD;
            st_d.por      = 1'b1;
            st_d.hold_cnt = '0;
            st_d.run_cnt  = '0;
        end else if (st_q.mode == MODE_HOLD) begin
            if (tick_ms) begin
                if (st_q.hold_cnt == hold_last) begin
                    st_d.mode     = MODE_RUN;
                    st_d.por      = 1'b0;
                    st_d.hold_cnt = '0;
                    st_d.run_cnt  = '0;
                end else begin
                    st_d.hold_cnt = st_q.hold_cnt + 1'b1;
                end
            end
        end else begin
            if (restart) begin
                st_d.run_cnt = '0;
            end else if (tick_ms) begin
                if (st_q.run_cnt == limit_m1) begin
                    st_d.mode     = MODE_HOLD;
                    st_d.por      = 1'b0;
                    st_d.hold_cnt = '0;
                    st_d.run_cnt  = '0;
                end else begin
                    st_d.run_cnt = st_q.run_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= MODE_HOLD;
            st_q.por      <= 1'b1;
            st_q.code     <= CODE_OFF;
            st_q.run_cnt  <= '0;
            st_q.hold_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_cnt_obs  = st_q.run_cnt;
    assign hold_cnt_obs = st_q.hold_cnt;

    wdg_reset_drive #(
        .ACTIVE_HIGH(RST_ACTIVE_HIGH)
    ) u_drive (
        .hold   (st_q.mode == MODE_HOLD),
        .rst_out(sys_rst)
    );

endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk #(
    parameter int CW              = 11,
    parameter int RUN_MAX         = 1400,
    parameter int HOLD_MAX        = 200,
    parameter bit RST_ACTIVE_HIGH = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_ms,
    input logic [1:0]    period_code,
    input logic          bus_start,
    input logic          supply_low,
    input logic          sys_rst,
    input logic [CW-1:0] run_cnt,
    input logic [CW-1:0] hold_cnt
);
    logic rst_act;
    assign rst_act = RST_ACTIVE_HIGH ? sys_rst : ~sys_rst;

    p_low_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> rst_act);

    p_off_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_act && !supply_low && period_code == 2'b11) |=> !rst_act);

    p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_act && !supply_low && bus_start) |=> (run_cnt == '0));

    p_code_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_act && !supply_low && period_code != $past(period_code)) |=> (run_cnt == '0));

    p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CW'(RUN_MAX));

    p_hold_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt < CW'(HOLD_MAX));

    p_release_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_act) |-> ($past(tick_ms) && !$past(supply_low)));

    p_assert_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_act) |-> ($past(tick_ms) || $past(supply_low)));

endmodule

bind wdg_supervisor wdg_supervisor_chk #(
    .CW             (CW),
    .RUN_MAX        (RUN_MAX),
    .HOLD_MAX       (HOLD_MAX),
    .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_ms    (tick_ms),
    .period_code(period_code),
    .bus_start  (bus_start),
    .supply_low (supply_low),
    .sys_rst    (sys_rst),
    .run_cnt    (run_cnt_obs),
    .hold_cnt   (hold_cnt_obs)
);

// File: tb/wdg_supervisor_test.sv
module wdg_supervisor_test;
    localparam int TL = 1400;
    localparam int TM = 600;
    localparam int TS = 200;
    localparam int TH = 200;
    localparam int TP = 200;
    localparam int TICK_DIV = 4;

    localparam int K_TIMEOUT = 0;
    localparam int K_RELEASE = 1;
    localparam int K_LOWSUP  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       bus_start = 1'b0;
    logic       supply_low = 1'b0;
    logic [1:0] period_code = 2'b11;
    logic       sys_rst;

    always #5 clk = ~clk;

    wdg_supervisor #(
        .TICKS_LONG(TL), .TICKS_MID(TM), .TICKS_SHORT(TS),
        .HOLD_TICKS(TH), .POR_TICKS(TP), .RST_ACTIVE_HIGH(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .period_code(period_code),
        .bus_start(bus_start), .supply_low(supply_low), .sys_rst(sys_rst)
    );

    typedef struct {
        int    kind;
        int    value;
        string req;
    } exp_item_t;

    exp_item_t expq[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int value, input string req);
        exp_item_t it;
        it.kind = kind;
        it.value = value;
        it.req = req;
        expq.push_back(it);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // time base: one-cycle tick every TICK_DIV clocks
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(posedge clk);
            #1 tick_ms = 1'b1;
            @(posedge clk);
            #1 tick_ms = 1'b0;
        end
    end

    // monitor: measures tick counts between reset edges and scores them
    bit         prev_rst = 1'b1;
    int         run_ticks = 0;
    int         hold_ticks = 0;
    logic [1:0] prev_code = 2'b11;

    task automatic score(input int kind, input int value);
        exp_item_t it;
        if (expq.size() == 0) begin
            check(1'b0, "unexpected reset edge (R2 R3 R4)", kind * 10000 + value, -1);
        end else begin
            it = expq.pop_front();
            n_checks++;
            if (it.kind != kind || it.value != value) begin
                n_fail++;
                $display("FAIL %s kind actual=%0d expected=%0d ticks actual=%0d expected=%0d",
                         it.req, kind, it.kind, value, it.value);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_rst   = 1'b1;
            run_ticks  = 0;
            hold_ticks = 0;
        end else begin
            if (sys_rst && !prev_rst) begin
                if (supply_low) score(K_LOWSUP, 0);
                else            score(K_TIMEOUT, run_ticks);
                run_ticks  = 0;
                hold_ticks = 0;
            end else if (!sys_rst && prev_rst) begin
                score(K_RELEASE, hold_ticks);
                run_ticks  = 0;
                hold_ticks = 0;
            end
            if (sys_rst) begin
                if (supply_low)   hold_ticks = 0;
                else if (tick_ms) hold_ticks++;
            end else begin
                if (supply_low || period_code == 2'b11 || bus_start || period_code != prev_code)
                    run_ticks = 0;
                else if (tick_ms)
                    run_ticks++;
            end
            prev_rst = sys_rst;
        end
        prev_code = period_code;
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        report();
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        cyc(n * TICK_DIV);
    endtask

    task automatic pulse_start();
        bus_start = 1'b1;
        @(posedge clk);
        #1 bus_start = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic wait_asserted();
        while (!sys_rst) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1 R10: asserted (high) during block reset
        cyc(5);
        @(negedge clk);
        check(sys_rst == 1'b1, "R1 R10 reset state", sys_rst, 1);
        push(K_RELEASE, TP, "R6 power-on hold");
        @(posedge clk);
        #1 rst_n = 1'b1;
        cyc(2);
        @(negedge clk);
        check(sys_rst == 1'b1, "R6 held after release", sys_rst, 1);
        drain();

        // R3: code 11 never times out
        ticks(2000);
        @(negedge clk);
        check(sys_rst == 1'b0, "R3 disabled code", sys_rst, 0);
        @(posedge clk);
        #1;

        // R2 short, then R9: restart and code change during hold ignored
        push(K_TIMEOUT, TS, "R2 short period");
        push(K_RELEASE, TH, "R9 hold unchanged");
        push(K_TIMEOUT, TM, "R2 mid period");
        push(K_RELEASE, TH, "R5 hold length");
        period_code = 2'b10;
        wait_asserted();
        ticks(20);
        pulse_start();
        period_code = 2'b01;
        ticks(20);
        pulse_start();
        drain();

        // R2 long
        push(K_TIMEOUT, TL, "R2 long period");
        push(K_RELEASE, TH, "R5 hold after long");
        period_code = 2'b00;
        drain();

        // R4: periodic restarts keep reset off
        period_code = 2'b10;
        for (int i = 0; i < 6; i++) begin
            ticks(150);
            pulse_start();
        end
        @(negedge clk);
        check(sys_rst == 1'b0, "R4 restarts keep alive", sys_rst, 0);
        push(K_TIMEOUT, TS, "R4 timeout from last restart");
        push(K_RELEASE, TH, "R5 hold after restart run");
        drain();

        // R7: code change restarts count
        ticks(150);
        period_code = 2'b01;
        push(K_TIMEOUT, TM, "R7 count restarted by code change");
        push(K_RELEASE, TH, "R5 hold after code change");
        drain();

        // R8: low supply forces reset and restarts the power-on hold
        ticks(100);
        push(K_LOWSUP, 0, "R8 low supply edge");
        supply_low = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(sys_rst == 1'b1, "R8 asserted next cycle", sys_rst, 1);
        @(posedge clk);
        #1;
        ticks(50);
        supply_low = 1'b0;
        ticks(100);
        @(negedge clk);
        check(sys_rst == 1'b1, "R8 held during recovery", sys_rst, 1);
        @(posedge clk);
        #1 supply_low = 1'b1;
        cyc(2);
        supply_low = 1'b0;
        push(K_RELEASE, TP, "R8 recovery hold");
        drain();

        ticks(10);
        check(expq.size() == 0, "R2 R5 scoreboard empty", expq.size(), 0);
        report();
    end

endmodule